// File: doc/BRIEF.md
# Counting General Purpose Register Bank

This block holds a small set of general purpose data registers that share one data bus. Each register can take the bus value, drive its stored value back onto the bus, or step up or down by one in place, so that loop counters and pointers need no trip through an arithmetic unit. A write selector picks the one register that may change on a clock edge. A separate read selector picks the register shown on the bus, so one register can be read while another is loaded or counted in the same cycle.

All control strobes are active low. A change needs the write strobe low together with either the load strobe or the count strobe. When both of those are low, load takes priority. The direction line picks up-counting when high and down-counting when low. Counting wraps modulo 2^DATA_W.

The tri-state bus driver is modelled as a data output plus a valid flag. When output is disabled, the flag is low and the data reads zero. The read path is combinational from the stored values, so the bus shows a register's content from before the coming clock edge.

Top module: `cnt_reg_bank`

## Requirements
- R1: A synchronous active-high `rst` clears every register to zero on the clock edge.
- R2: Both selectors use the same code: 0 selects a, 1 selects b, 2 selects c and 3 selects d. With `oe_n` low, `bus_vld` is 1 and `bus_out` equals the register picked by `rd_sel`.
- R3: With `oe_n` high, `bus_vld` is 0 and `bus_out` is zero, whatever the selectors and stored values are.
- R4: With `we_n` low and `ld_n` low, the register picked by `wr_sel` takes `bus_in` on the next edge.
- R5: With `we_n` low, `ld_n` high, `cnt_n` low and `dir_dn_n` high, the selected register increments by one on the edge. The value 255 wraps to 0.
- R6: With `we_n` low, `ld_n` high, `cnt_n` low and `dir_dn_n` low, the selected register decrements by one on the edge. The value 0 wraps to 255.
- R7: When `ld_n` and `cnt_n` are both low, the register loads `bus_in` and does not count.
- R8: With `we_n` high, no register changes, even when `ld_n` or `cnt_n` is low.
- R9: On any edge, only the register picked by `wr_sel` may change. All other registers hold their values.
- R10: The read and write selectors are independent. When a register is both read and written in one cycle, `bus_out` shows its value from before the edge. The new value appears in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_sel | input | SEL_W | Register to load or count |
| rd_sel | input | SEL_W | Register to drive onto the bus |
| we_n | input | 1 | Write qualifier, active low |
| oe_n | input | 1 | Bus drive enable, active low |
| ld_n | input | 1 | Load from bus, active low |
| cnt_n | input | 1 | Count enable, active low |
| dir_dn_n | input | 1 | Count direction: high counts up, low counts down |
| bus_in | input | DATA_W | Value on the shared bus to load |
| bus_out | output | DATA_W | Selected register value, zero when not driving |
| bus_vld | output | 1 | High while the bank drives the bus |

## Verification
The bench builds the bank with its default values: four registers of eight bits, with two-bit selectors. At this width, both wrap points (255 to 0 and 0 to 255) are only one or two count steps away from a loaded value. Every selector code maps to a real register, so each code is exercised for both reading and writing. The bench also covers read-while-write on one register and the load-over-count priority. It checks that write-inhibited strobes leave every register unchanged, as seen through the bus.

// File: rtl/gpr_pkg.sv
package gpr_pkg;

    // Per-cell action for one clock edge
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_INC  = 2'd2,
        OP_DEC  = 2'd3
    } cell_op_e;

    // Active-low modification strobes grouped together
    typedef struct packed {
        logic we_n;
        logic ld_n;
        logic cnt_n;
        logic dir_dn_n;
    } strobe_t;

    // Resolve the strobes into one action; load wins over count
    function automatic cell_op_e pick_op(input strobe_t s);
        cell_op_e r;
        r = OP_HOLD;
        if (!s.we_n) begin
            if (!s.ld_n)
                r = OP_LOAD;
            else if (!s.cnt_n)
                r = s.dir_dn_n ? OP_INC : OP_DEC;
        end
        pick_op = r;
    endfunction

endpackage

// File: rtl/gpr_wr_decode.sv
module gpr_wr_decode
    import gpr_pkg::*;
#(
    parameter int NUM_REGS = 4,
    parameter int SEL_W    = 2
) (
    input  logic [SEL_W-1:0]              wr_sel,
    input  cell_op_e                      op,
    output cell_op_e [NUM_REGS-1:0]       cell_ops
);

    // Route the resolved action to the selected cell only
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_route
        assign cell_ops[i] = (wr_sel == SEL_W'(i)) ? op : OP_HOLD;
    end

endmodule

// File: rtl/gpr_cell.sv
module gpr_cell
    import gpr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  cell_op_e          op,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            unique case (op)
                OP_LOAD: q <= din;
                OP_INC:  q <= q + DATA_W'(1);
                OP_DEC:  q <= q - DATA_W'(1);
                default: q <= q;
            endcase
        end
    end

endmodule

// File: rtl/gpr_rd_mux.sv
module gpr_rd_mux #(
    parameter int NUM_REGS = 4,
    parameter int DATA_W   = 8,
    parameter int SEL_W    = 2
) (
    input  logic [NUM_REGS-1:0][DATA_W-1:0] regs,
    input  logic [SEL_W-1:0]                rd_sel,
    input  logic                            oe_n,
    output logic [DATA_W-1:0]               bus_out,
    output logic                            bus_vld
);

    always_comb begin
        bus_vld = ~oe_n;
        bus_out = '0;
        if (!oe_n)
            bus_out = regs[rd_sel];
    end

endmodule

// File: rtl/cnt_reg_bank.sv
module cnt_reg_bank
    import gpr_pkg::*;
#(
    parameter  int DATA_W   = 8,
    parameter  int NUM_REGS = 4,
    localparam int SEL_W    = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [SEL_W-1:0]  rd_sel,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              ld_n,
    input  logic              cnt_n,
    input  logic              dir_dn_n,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_vld
);

    strobe_t                          strb;
    cell_op_e                         op;
    cell_op_e [NUM_REGS-1:0]          cell_ops;
    logic [NUM_REGS-1:0][DATA_W-1:0]  regs_q;

    assign strb = '{we_n: we_n, ld_n: ld_n, cnt_n: cnt_n, dir_dn_n: dir_dn_n};
    assign op   = pick_op(strb);

    gpr_wr_decode #(
        .NUM_REGS (NUM_REGS),
        .SEL_W    (SEL_W)
    ) u_dec (
        .wr_sel   (wr_sel),
        .op       (op),
        .cell_ops (cell_ops)
    );

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_cell
        gpr_cell #(
            .DATA_W (DATA_W)
        ) u_cell (
            .clk (clk),
            .rst (rst),
            .op  (cell_ops[i]),
            .din (bus_in),
            .q   (regs_q[i])
        );
    end

    gpr_rd_mux #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W),
        .SEL_W    (SEL_W)
    ) u_mux (
        .regs    (regs_q),
        .rd_sel  (rd_sel),
        .oe_n    (oe_n),
        .bus_out (bus_out),
        .bus_vld (bus_vld)
    );

endmodule

// File: rtl/gpr_bank_chk.sv
module gpr_bank_chk #(
    parameter  int DATA_W   = 8,
    parameter  int NUM_REGS = 4,
    localparam int SEL_W    = $clog2(NUM_REGS)
) (
    input logic                            clk,
    input logic                            rst,
    input logic [SEL_W-1:0]                wr_sel,
    input logic [SEL_W-1:0]                rd_sel,
    input logic                            we_n,
    input logic                            oe_n,
    input logic                            ld_n,
    input logic                            cnt_n,
    input logic                            dir_dn_n,
    input logic [DATA_W-1:0]               bus_in,
    input logic [DATA_W-1:0]               bus_out,
    input logic                            bus_vld,
    input logic [NUM_REGS-1:0][DATA_W-1:0] regs_q
);

    // R3
    idle_bus_chk: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> (!bus_vld && bus_out == '0));

    // R2
    drive_bus_chk: assert property (@(posedge clk) disable iff (rst)
        !oe_n |-> (bus_vld && bus_out == regs_q[rd_sel]));

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        // R4
        load_take_chk: assert property (@(posedge clk) disable iff (rst)
            (!we_n && !ld_n && wr_sel == SEL_W'(i)) |=> regs_q[i] == $past(bus_in));

        // R5
        count_up_chk: assert property (@(posedge clk) disable iff (rst)
            (!we_n && ld_n && !cnt_n && dir_dn_n && wr_sel == SEL_W'(i))
            |=> regs_q[i] == DATA_W'($past(regs_q[i]) + DATA_W'(1)));

        // R6
        count_down_chk: assert property (@(posedge clk) disable iff (rst)
            (!we_n && ld_n && !cnt_n && !dir_dn_n && wr_sel == SEL_W'(i))
            |=> regs_q[i] == DATA_W'($past(regs_q[i]) - DATA_W'(1)));

        // R8 R9
        hold_other_chk: assert property (@(posedge clk) disable iff (rst)
            (we_n || wr_sel != SEL_W'(i) || (ld_n && cnt_n)) |=> $stable(regs_q[i]));
    end

endmodule

bind cnt_reg_bank gpr_bank_chk #(
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_sel   (wr_sel),
    .rd_sel   (rd_sel),
    .we_n     (we_n),
    .oe_n     (oe_n),
    .ld_n     (ld_n),
    .cnt_n    (cnt_n),
    .dir_dn_n (dir_dn_n),
    .bus_in   (bus_in),
    .bus_out  (bus_out),
    .bus_vld  (bus_vld),
    .regs_q   (regs_q)
);

// File: tb/cnt_reg_bank_test.sv
module cnt_reg_bank_test;

    localparam int DW = 8;
    localparam int NR = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    wr_sel = '0;
    logic [1:0]    rd_sel = '0;
    logic          we_n = 1'b1;
    logic          oe_n = 1'b1;
    logic          ld_n = 1'b1;
    logic          cnt_n = 1'b1;
    logic          dir_dn_n = 1'b1;
    logic [DW-1:0] bus_in = '0;
    logic [DW-1:0] bus_out;
    logic          bus_vld;

    int checks = 0;
    int fails  = 0;
    bit over   = 1'b0;

    logic [DW-1:0] model [NR];

    logic [DW-1:0] q_data [$];
    logic          q_vld  [$];
    string         q_tag  [$];

    always #4 clk = ~clk;   // 125 MHz

    cnt_reg_bank #(.DATA_W(DW), .NUM_REGS(NR)) uut (
        .clk      (clk),
        .rst      (rst),
        .wr_sel   (wr_sel),
        .rd_sel   (rd_sel),
        .we_n     (we_n),
        .oe_n     (oe_n),
        .ld_n     (ld_n),
        .cnt_n    (cnt_n),
        .dir_dn_n (dir_dn_n),
        .bus_in   (bus_in),
        .bus_out  (bus_out),
        .bus_vld  (bus_vld)
    );

    // Driver: drive one cycle, queue expected bus state, advance model
    task automatic step(input logic [1:0] ws, input logic [1:0] rs,
                        input logic w, input logic o, input logic l,
                        input logic c, input logic d, input logic [DW-1:0] din,
                        input bit chk, input string tag);
        @(negedge clk);
        wr_sel = ws; rd_sel = rs; we_n = w; oe_n = o;
        ld_n = l; cnt_n = c; dir_dn_n = d; bus_in = din;
        if (chk) begin
            q_data.push_back(o ? '0 : model[rs]);
            q_vld.push_back(~o);
            q_tag.push_back(tag);
        end
        if (!w) begin
            if (!l)
                model[ws] = din;
            else if (!c)
                model[ws] = d ? DW'(model[ws] + DW'(1)) : DW'(model[ws] - DW'(1));
        end
    endtask

    task automatic rd(input logic [1:0] rs, input string tag);
        step(2'd0, rs, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, '0, 1'b1, tag);
    endtask

    task automatic load(input logic [1:0] ws, input logic [DW-1:0] v);
        step(ws, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, v, 1'b0, "");
    endtask

    task automatic count(input logic [1:0] ws, input logic up);
        step(ws, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, up, '0, 1'b0, "");
    endtask

    task automatic pulse_reset();
        @(negedge clk);
        rst = 1'b1; we_n = 1'b1; ld_n = 1'b1; cnt_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < NR; i++) model[i] = '0;
    endtask

    // Monitor: compare the bus with queued expectations mid-cycle
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (q_tag.size() > 0) begin
                logic [DW-1:0] ed;
                logic          ev;
                string         et;
                ed = q_data.pop_front();
                ev = q_vld.pop_front();
                et = q_tag.pop_front();
                checks++;
                if (bus_out !== ed || bus_vld !== ev) begin
                    fails++;
                    $display("FAIL %s: got data=%02h vld=%0b, expected data=%02h vld=%0b",
                             et, bus_out, bus_vld, ed, ev);
                end
            end
        end
    end

    initial begin
        #(8 * 5000);
        if (!over) begin
            over = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NR; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int i = 0; i < NR; i++) rd(2'(i), "R1 reset value");

        // R4 loads, R2 read encoding
        load(2'd0, 8'h11);
        load(2'd1, 8'h22);
        load(2'd2, 8'h33);
        load(2'd3, 8'hFE);
        rd(2'd0, "R2 code 0 reads a");
        rd(2'd1, "R2 code 1 reads b");
        rd(2'd2, "R4 load c");
        rd(2'd3, "R4 load d");

        // R3 bus idle
        step(2'd0, 2'd3, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, '0, 1'b1, "R3 idle bus");
        step(2'd0, 2'd1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, '0, 1'b1, "R3 idle bus b");

        // R5 count up with wrap
        count(2'd3, 1'b1);
        rd(2'd3, "R5 count up to FF");
        count(2'd3, 1'b1);
        rd(2'd3, "R5 wrap to 00");

        // R6 count down with wrap
        load(2'd2, 8'h00);
        count(2'd2, 1'b0);
        rd(2'd2, "R6 wrap to FF");
        count(2'd2, 1'b0);
        rd(2'd2, "R6 count down to FE");

        // R7 load over count
        step(2'd1, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'hA5, 1'b0, "");
        rd(2'd1, "R7 load priority");

        // R8 inhibited write
        step(2'd1, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h99, 1'b1, "R8 before");
        step(2'd1, 2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h99, 1'b1, "R8 load blocked");
        rd(2'd1, "R8 count blocked");

        // R9 others untouched after writes to b
        rd(2'd0, "R9 a held");
        rd(2'd2, "R9 c held");
        rd(2'd3, "R9 d held");

        // R10 read and write the same register
        step(2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h5A, 1'b1, "R10 old value");
        rd(2'd0, "R10 new value");
        step(2'd3, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, '0, 1'b1, "R10 read a while counting d");
        rd(2'd3, "R10 d counted");

        // R1 reset from non-zero
        pulse_reset();
        for (int i = 0; i < NR; i++) rd(2'(i), "R1 cleared");

        repeat (3) @(negedge clk);
        if (!over) begin
            over = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule